// File: doc/BRIEF.md
# Contact Card Session Sequencer

This block is the digital controller that sits between a host and the analog front end of a contact smart-card slot. It switches the charge-pump booster, the card supply, the card data-line buffers and the card clock on and off in a fixed order. It also drives the card reset line and an active-low status pin. All session timing is counted in half-units of a slow time base `T`, which is `TICK_DIV` cycles of the oscillator clock. The regulators and slope shaping are outside the block; the block only drives their enables.

The host opens a session by pulling `start_n` low while the block is idle. It closes the session by raising `start_n` again, and the block then powers the slot down in the reverse order. If the card is pulled out, the supply is overloaded or the die overheats, the block starts the same power-down at once without waiting for the host, and it flags the cause on `off_n`. A supply alarm also forces a power-down. After an alarm, and after reset, the block ignores the host for a hold time of `POR_T` units of `T`.

While `start_n` is high, `off_n` reports whether a card is present. A card counts as present when `pres_hi` is high or when `pres_lo_n` is low. The host can use `rst_req` to gate the card clock. If `rst_req` is high when the session starts, the clock is held off until the host drops `rst_req`, which lets the host count exact clock pulses before the card leaves reset. All inputs are taken as synchronous to `clk`.

Top module: `card_session_seq`

## Requirements
- R1: While reset is asserted, and for `POR_T` units of T after reset is released (or after an alarm), every enable and `card_rst` stay low, and `start_n` going low has no effect.
- R2: While `start_n` is high, `off_n` is high exactly when `pres_hi` is 1 or `pres_lo_n` is 0.
- R3: The cycle after the idle block samples `start_n` low is t1. At t1 `boost_en` rises, `vcc_en` rises at t1+T/2, and `io_en` rises at t1+4T.
- R4: If `rst_req` was low when the session started, `clk_en` rises together with `io_en` at t1+4T.
- R5: If `rst_req` was high when the session started, `clk_en` stays low until `rst_req` falls inside the window from t1+4T to t1+7T. `clk_en` then rises one cycle after the fall is sampled. If `rst_req` never falls, `clk_en` rises at t1+7T.
- R6: `card_rst` is low until t1+7T and then follows `rst_req`. Once the clock is running, a change of `rst_req` does not stop the clock.
- R7: When `start_n` goes high during a session, the first deactivation cycle is t11. At t11 `card_rst` goes low. `clk_en` goes low at t11+T/2, `io_en` at t11+T, `vcc_en` at t11+3.5T and `boost_en` at t11+5T.
- R8: During a session, card removal, `ovc` or `ovt` starts the R7 power-down in the next cycle and drives `off_n` low. `off_n` stays low, even if the card returns, until `start_n` goes high. An emergency power-down during activation turns off only the outputs that were already on.
- R9: `alarm` during a session starts the R7 power-down, but `off_n` stays high. When the power-down is complete, the R1 hold time applies.
- R10: A new session starts only from idle. After any power-down that completes while `start_n` is low, the host must raise `start_n` before it can lower it again to start a session.
- R11: At all times `card_rst` implies `clk_en`, `clk_en` implies `io_en`, `io_en` implies `vcc_en`, and `vcc_en` implies `boost_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Session command, low = session requested |
| rst_req | input | 1 | Host card-reset request, active high |
| pres_hi | input | 1 | Presence switch, active high |
| pres_lo_n | input | 1 | Presence switch, active low |
| ovc | input | 1 | Card supply overcurrent flag |
| ovt | input | 1 | Overtemperature flag |
| alarm | input | 1 | Host supply low alarm |
| boost_en | output | 1 | Booster enable |
| vcc_en | output | 1 | Card supply enable |
| io_en | output | 1 | Data-line buffer enable |
| clk_en | output | 1 | Card clock enable |
| card_rst | output | 1 | Card reset line |
| off_n | output | 1 | Presence/fault status, active low |

## Verification
The bench builds the block with `TICK_DIV`=8 and `POR_T`=3. This makes a half unit four cycles long and the hold time 24 cycles, so every step edge of activation and power-down can be checked at the exact cycle on each side of it. With these short values the bench can also run the hold time twice and cover several sessions: clock held by `rst_req`, clock forced at t1+7T, overcurrent during ON, overtemperature in mid-activation, a card that bounces back after removal, and a supply alarm.

// File: rtl/card_seq_pkg.sv
package card_seq_pkg;
  typedef enum logic [2:0] {
    ST_POR, ST_IDLE, ST_ACT, ST_ON, ST_DEACT, ST_HOLD
  } seq_state_e;

  // Step thresholds, in half units of T, counted from t1 or t11
  localparam logic [3:0] ACT_VCC  = 4'd1;
  localparam logic [3:0] ACT_IO   = 4'd8;
  localparam logic [3:0] ACT_LAST = 4'd13; // step 14 = t5
  localparam logic [3:0] DE_CLK   = 4'd1;
  localparam logic [3:0] DE_IO    = 4'd2;
  localparam logic [3:0] DE_VCC   = 4'd7;
  localparam logic [3:0] DE_LAST  = 4'd9;  // step 10 = booster off
endpackage

// File: rtl/half_tick_gen.sv
module half_tick_gen #(
  parameter int HALF = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int DW = (HALF > 2) ? $clog2(HALF) : 1;
  localparam logic [DW-1:0] LAST = DW'(HALF - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             div_q <= '0;
    else if (clr)           div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                    div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/por_hold.sv
module por_hold #(
  parameter int HALVES = 800
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic alarm,
  input  logic tick,
  output logic done
);
  localparam int PW = (HALVES > 2) ? $clog2(HALVES) : 1;
  localparam logic [PW-1:0] LAST = PW'(HALVES - 1);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (!run || alarm)  cnt_q <= '0;
    else if (tick && !done)  cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && !alarm && tick && (cnt_q == LAST);
endmodule

// File: rtl/fault_status.sv
module fault_status (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  input  logic present,
  input  logic ovc,
  input  logic ovt,
  input  logic in_session,
  output logic off_n
);
  logic fault_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fault_q <= 1'b0;
    else if (start_n) fault_q <= 1'b0;
    else if (in_session && (!present || ovc || ovt)) fault_q <= 1'b1;
  end

  assign off_n = start_n ? present : !fault_q;
endmodule

// File: rtl/session_fsm.sv
module session_fsm
  import card_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  input  logic rst_req,
  input  logic fault,
  input  logic alarm,
  input  logic tick,
  input  logic por_done,
  output logic seq_clr,
  output logic in_por,
  output logic in_session,
  output logic boost_en,
  output logic vcc_en,
  output logic io_en,
  output logic clk_en,
  output logic card_rst
);
  seq_state_e st_q, st_d;
  logic [3:0] step_q;
  logic hold_q, alarm_pend_q;
  logic vcc_q, io_q, clk_q;
  logic abort, vcc_up, io_up, clk_up, live, down;

  assign live  = (st_q == ST_ACT) || (st_q == ST_ON);
  assign down  = (st_q == ST_DEACT);
  assign abort = start_n || fault || alarm;

  always_comb begin
    st_d    = st_q;
    seq_clr = 1'b0;
    unique case (st_q)
      ST_POR:   if (por_done) st_d = start_n ? ST_IDLE : ST_HOLD;
      ST_IDLE:  if (alarm) st_d = ST_POR;
                else if (!start_n) begin st_d = ST_ACT; seq_clr = 1'b1; end
      ST_HOLD:  if (alarm) st_d = ST_POR;
                else if (start_n) st_d = ST_IDLE;
      ST_ACT:   if (abort) begin st_d = ST_DEACT; seq_clr = 1'b1; end
                else if (tick && step_q == ACT_LAST) st_d = ST_ON;
      ST_ON:    if (abort) begin st_d = ST_DEACT; seq_clr = 1'b1; end
      ST_DEACT: if (tick && step_q == DE_LAST)
                  st_d = (alarm_pend_q || alarm) ? ST_POR
                       : (start_n ? ST_IDLE : ST_HOLD);
      default:  st_d = ST_POR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_POR;
      step_q <= '0;
      hold_q <= 1'b0;
      alarm_pend_q <= 1'b0;
      vcc_q <= 1'b0;
      io_q <= 1'b0;
      clk_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (seq_clr) step_q <= '0;
      else if (tick && (live || down)) step_q <= step_q + 4'd1;
      if (st_q == ST_IDLE && st_d == ST_ACT) hold_q <= rst_req;
      if (st_q == ST_POR) alarm_pend_q <= 1'b0;
      else if (alarm)     alarm_pend_q <= 1'b1;
      if (live) begin
        vcc_q <= vcc_q | vcc_up;
        io_q  <= io_q  | io_up;
        clk_q <= clk_q | clk_up;
      end else if (!down) begin
        vcc_q <= 1'b0;
        io_q  <= 1'b0;
        clk_q <= 1'b0;
      end
    end
  end

  assign vcc_up = (st_q == ST_ON) || (st_q == ST_ACT && step_q >= ACT_VCC);
  assign io_up  = (st_q == ST_ON) || (st_q == ST_ACT && step_q >= ACT_IO);
  assign clk_up = (st_q == ST_ON) ||
                  (st_q == ST_ACT && step_q >= ACT_IO && (!hold_q || !rst_req));

  assign boost_en   = live || down;
  assign vcc_en     = vcc_up || (down && vcc_q && step_q < DE_VCC);
  assign io_en      = io_up  || (down && io_q  && step_q < DE_IO);
  assign clk_en     = clk_up || (live && clk_q) || (down && clk_q && step_q < DE_CLK);
  assign card_rst   = (st_q == ST_ON) && rst_req;
  assign in_por     = (st_q == ST_POR);
  assign in_session = live;
endmodule

// File: rtl/card_session_seq.sv
module card_session_seq #(
  parameter int TICK_DIV = 64,
  parameter int POR_T    = 400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_n,
  input  logic rst_req,
  input  logic pres_hi,
  input  logic pres_lo_n,
  input  logic ovc,
  input  logic ovt,
  input  logic alarm,
  output logic boost_en,
  output logic vcc_en,
  output logic io_en,
  output logic clk_en,
  output logic card_rst,
  output logic off_n
);
  localparam int HALF   = TICK_DIV / 2;
  localparam int HALVES = 2 * POR_T;

  logic present, fault, tick, seq_clr, in_por, in_session, por_done;

  assign present = pres_hi || !pres_lo_n;
  assign fault   = !present || ovc || ovt;

  half_tick_gen #(.HALF(HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .clr(seq_clr), .tick(tick)
  );

  por_hold #(.HALVES(HALVES)) u_por (
    .clk(clk), .rst_n(rst_n), .run(in_por), .alarm(alarm),
    .tick(tick), .done(por_done)
  );

  session_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .rst_req(rst_req),
    .fault(fault), .alarm(alarm), .tick(tick), .por_done(por_done),
    .seq_clr(seq_clr), .in_por(in_por), .in_session(in_session),
    .boost_en(boost_en), .vcc_en(vcc_en), .io_en(io_en),
    .clk_en(clk_en), .card_rst(card_rst)
  );

  fault_status u_stat (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .present(present),
    .ovc(ovc), .ovt(ovt), .in_session(in_session), .off_n(off_n)
  );
endmodule

// File: rtl/card_session_seq_chk.sv
module card_session_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start_n,
  input logic boost_en,
  input logic vcc_en,
  input logic io_en,
  input logic clk_en,
  input logic card_rst,
  input logic off_n
);
  assert_rst_needs_clk_R6: assert property (@(posedge clk) disable iff (!rst_n)
    card_rst |-> (clk_en && io_en && vcc_en));

  assert_clk_needs_io_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> io_en);

  assert_io_needs_vcc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    io_en |-> vcc_en);

  assert_vcc_needs_boost_R11: assert property (@(posedge clk) disable iff (!rst_n)
    vcc_en |-> boost_en);

  assert_start_by_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boost_en) |-> $past(!start_n));

  assert_fault_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_n && !off_n) |=> (start_n || !off_n));

  assert_clk_before_io_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(io_en) |-> !clk_en);
endmodule

bind card_session_seq card_session_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_n(start_n), .boost_en(boost_en),
  .vcc_en(vcc_en), .io_en(io_en), .clk_en(clk_en), .card_rst(card_rst),
  .off_n(off_n)
);

// File: tb/tb_card_session_seq.sv
module tb_card_session_seq;
  localparam int CLK_P = 10;
  localparam int TD    = 8;
  localparam int PT    = 3;
  localparam int H     = TD / 2;
  localparam int PORC  = 2 * PT * H;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start_n = 1'b1, rst_req = 1'b0, pres_hi = 1'b1, pres_lo_n = 1'b1;
  logic ovc = 1'b0, ovt = 1'b0, alarm = 1'b0;
  logic boost_en, vcc_en, io_en, clk_en, card_rst, off_n;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  card_session_seq #(.TICK_DIV(TD), .POR_T(PT)) dut (
    .clk(clk), .rst_n(rst_n), .start_n(start_n), .rst_req(rst_req),
    .pres_hi(pres_hi), .pres_lo_n(pres_lo_n), .ovc(ovc), .ovt(ovt),
    .alarm(alarm), .boost_en(boost_en), .vcc_en(vcc_en), .io_en(io_en),
    .clk_en(clk_en), .card_rst(card_rst), .off_n(off_n)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Lower start_n at a negedge; returns at the sample point of cycle 0 (t1).
  task automatic begin_act(input logic rr);
    rst_req = rr;
    start_n = 1'b0;
    adv(1);
  endtask

  // Full normal power-down from any session state, ends idle.
  task automatic end_session();
    start_n = 1'b1;
    adv(10 * H + 2);
  endtask

  task automatic t_reset_por();
    check("R1 reset boost", boost_en, 0);
    check("R1 reset rst", card_rst, 0);
    adv(1);
    rst_n = 1'b1;
    adv(PORC - 3);
    start_n = 1'b0;
    adv(1);
    start_n = 1'b1;
    check("R1 start ignored in hold", boost_en, 0);
    adv(1);
    check("R1 still off", boost_en, 0);
    adv(3);
    pres_hi = 1'b0; pres_lo_n = 1'b1; adv(1);
    check("R2 absent", off_n, 0);
    pres_lo_n = 1'b0; adv(1);
    check("R2 active-low present", off_n, 1);
    pres_hi = 1'b1; pres_lo_n = 1'b1; adv(1);
    check("R2 active-high present", off_n, 1);
  endtask

  task automatic t_act_plain();
    begin_act(1'b0);
    check("R3 boost at t1", boost_en, 1);
    check("R3 vcc off at t1", vcc_en, 0);
    adv(H - 1); check("R3 vcc before T/2", vcc_en, 0);
    adv(1);     check("R3 vcc at T/2", vcc_en, 1);
    adv(7 * H - 1);
    check("R3 io before 4T", io_en, 0);
    check("R4 clk before 4T", clk_en, 0);
    adv(1);
    check("R3 io at 4T", io_en, 1);
    check("R4 clk at 4T", clk_en, 1);
    adv(4 * H);
    rst_req = 1'b1;
    adv(2 * H - 1);
    check("R6 rst held low before t5", card_rst, 0);
    adv(1);
    check("R6 rst follows at t5", card_rst, 1);
    rst_req = 1'b0; adv(1);
    check("R6 rst follows low", card_rst, 0);
    check("R6 clk unaffected", clk_en, 1);
  endtask

  task automatic t_normal_deact();
    start_n = 1'b1; adv(1);
    check("R7 rst low at t11", card_rst, 0);
    check("R7 clk at t11", clk_en, 1);
    adv(H - 1);     check("R7 clk before T/2", clk_en, 1);
    adv(1);         check("R7 clk off T/2", clk_en, 0);
    adv(H - 1);     check("R7 io before T", io_en, 1);
    adv(1);         check("R7 io off T", io_en, 0);
    adv(5 * H - 1); check("R7 vcc before 3.5T", vcc_en, 1);
    adv(1);         check("R7 vcc off 3.5T", vcc_en, 0);
    adv(3 * H - 1); check("R7 boost before 5T", boost_en, 1);
    adv(1);         check("R7 boost off 5T", boost_en, 0);
    adv(2);
  endtask

  task automatic t_held_clock();
    begin_act(1'b1);
    adv(8 * H);
    check("R5 io on, clk held", io_en, 1);
    check("R5 clk held", clk_en, 0);
    adv(2 * H);
    check("R5 clk held mid window", clk_en, 0);
    rst_req = 1'b0; adv(1);
    check("R5 clk after release", clk_en, 1);
    rst_req = 1'b1; adv(1);
    check("R5 clk latched on", clk_en, 1);
    check("R6 rst low before t5", card_rst, 0);
    adv(4 * H - 2);
    check("R6 rst at t5", card_rst, 1);
    end_session();
    begin_act(1'b1);
    adv(14 * H - 1);
    check("R5 clk off before t5", clk_en, 0);
    adv(1);
    check("R5 clk forced at t5", clk_en, 1);
    end_session();
    rst_req = 1'b0;
  endtask

  task automatic t_fault();
    begin_act(1'b0);
    adv(15 * H);
    ovc = 1'b1; adv(1);
    check("R8 ovc off_n", off_n, 0);
    check("R8 ovc rst", card_rst, 0);
    check("R8 ovc deact running", boost_en, 1);
    ovc = 1'b0;
    adv(10 * H);
    check("R8 deact done", boost_en, 0);
    check("R8 off_n sticky", off_n, 0);
    adv(5);
    check("R10 no restart while low", boost_en, 0);
    start_n = 1'b1; adv(1);
    check("R8 released reports presence", off_n, 1);
    start_n = 1'b0; adv(1);
    check("R10 restart after release", boost_en, 1);
    adv(2 * H);
    ovt = 1'b1; adv(1);
    ovt = 1'b0;
    check("R8 ovt off_n", off_n, 0);
    check("R8 partial io stays off", io_en, 0);
    check("R8 partial vcc kept", vcc_en, 1);
    end_session();
  endtask

  task automatic t_removal();
    begin_act(1'b0);
    adv(15 * H);
    pres_hi = 1'b0; adv(1);
    check("R8 removal off_n", off_n, 0);
    pres_hi = 1'b1; adv(1);
    check("R8 return ignored", off_n, 0);
    check("R8 deact not aborted", boost_en, 1);
    adv(4);
    check("R8 clk down after return", clk_en, 0);
    adv(10 * H);
    check("R8 removal deact done", boost_en, 0);
    start_n = 1'b1; adv(1);
    check("R2 present after removal", off_n, 1);
  endtask

  task automatic t_alarm();
    begin_act(1'b0);
    adv(15 * H);
    alarm = 1'b1; adv(1);
    check("R9 off_n high on alarm", off_n, 1);
    check("R9 rst low", card_rst, 0);
    adv(2); alarm = 1'b0;
    adv(10 * H - 2);
    check("R9 deact done", boost_en, 0);
    check("R9 off_n still high", off_n, 1);
    start_n = 1'b1; adv(2);
    start_n = 1'b0; adv(2);
    check("R9 hold after alarm", boost_en, 0);
    start_n = 1'b1;
    adv(PORC + H + 4);
    begin_act(1'b0);
    check("R9 start after hold", boost_en, 1);
    end_session();
  endtask

  initial begin
    adv(2);
    t_reset_por();
    t_act_plain();
    t_normal_deact();
    t_held_clock();
    t_fault();
    t_removal();
    t_alarm();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule